// File: doc/BRIEF.md
# Microcode Step Sequencer with Memory Wait

This block is the control unit of a single-bus processor. A step counter walks through a small hard-wired control store. Each cycle the store emits a complete control word for the datapath. The first three steps are shared by every instruction: the instruction fetch overlaps with the program-counter increment, and the instruction register is then loaded. From step 3 onward, the opcode selects one of three routines: a register move, an add from an absolute address, or a branch taken when the negative flag is set.

A control word can request a memory wait. The counter then holds its step until the memory reports completion. The word on the output during the final cycle of the wait is the one that takes effect on the advancing edge. A control word can also carry an end bit. When the step advances, the end bit returns the counter to step 0 so the next fetch begins. The branch routine makes its end bit conditional on the negative flag. An opcode the block does not recognise ends the instruction at step 3 and raises an illegal-instruction flag.

The block has no data stream of its own. All of its pins are plain control and status signals sampled on the rising clock edge, so it applies no back-pressure.

Top module: `mseq_sequencer`

## Requirements
- R1: While the synchronous reset `rst` is high, `ctrl` is all zero. The first rising edge that samples `rst` high puts `step_idx` at 0.
- R2: Control word bit positions: 0 pc_drive, 1 pc_load, 2 mar_load, 3 mem_read, 4 zero_a, 5 carry_in, 6 alu_add, 7 z_load, 8 z_drive, 9 mem_wait, 10 mdr_drive, 11 ir_load, 12 addr_drive, 13 y_load, 14 set_cc, 15 end, 16 src_drive, 17 dst_load, 18 r1_drive, 19 r1_load. Step 0 asserts exactly pc_drive, mar_load, mem_read, zero_a, carry_in, alu_add and z_load.
- R3: Step 1 asserts exactly z_drive, pc_load and mem_wait. Step 2 asserts exactly mdr_drive and ir_load.
- R4: In a step whose word has mem_wait, `step_idx` holds as long as `mem_done` is low. It advances on the first edge where `mem_done` is high.
- R5: On an advancing edge, a word with end sends `step_idx` to 0. Any other advancing word increments `step_idx` by one.
- R6: Opcode 1 (move) runs a single step 3 with src_drive, dst_load and end.
- R7: Opcode 2 (add from absolute address) runs four steps:
  - step 3: addr_drive, mar_load, mem_read
  - step 4: r1_drive, y_load, mem_wait
  - step 5: mdr_drive, alu_add, z_load, set_cc
  - step 6: z_drive, r1_load, end
- R8: Opcode 3 (branch if negative) runs up to three steps:
  - step 3: pc_drive, y_load, plus end when `flag_n` is 0
  - step 4: addr_drive, alu_add, z_load
  - step 5: z_drive, pc_load, end
- R9: set_cc appears only in step 5 of the add routine. It never appears in steps 0 to 2.
- R10: Any opcode other than 1, 2 or 3 gives step 3 a word of only end, and `illegal_op` is high in that cycle. `illegal_op` is low in every other cycle.
- R11: The opcode is taken from `ir_opcode` in step 3. A change on `ir_opcode` during steps 4 to 6 has no effect on `ctrl`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ir_opcode | input | 4 | Opcode field from the instruction register |
| flag_n | input | 1 | Negative condition flag |
| mem_done | input | 1 | Memory operation complete |
| ctrl | output | 20 | Datapath control word for the current step |
| step_idx | output | 3 | Current step number |
| illegal_op | output | 1 | Unknown opcode seen at step 3 |

## Verification
The in-design assertions check the following on every cycle:
- the counter holds during a wait without completion
- the counter returns to 0 after an advancing end
- the counter increments by one otherwise
- set_cc stays confined to the add routine's step 5
- an illegal opcode always ends the instruction
- the latched routine stays stable through the later execute steps

Only the bench scenarios can show the following:
- the exact bit contents of each step of each routine
- the dependence of the branch length on the negative flag
- the stall counts that follow from a given memory latency
- the immunity to opcode changes after step 3

The bench sweeps every opcode, both flag values and memory latencies 0 to 3 to cover these.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
  localparam int CW_W   = 20;
  localparam int OP_W   = 4;
  localparam int STEP_W = 3;
  localparam int FETCH_LEN = 3;

  localparam int B_PC_DRV   = 0;
  localparam int B_PC_LD    = 1;
  localparam int B_MAR_LD   = 2;
  localparam int B_MEM_RD   = 3;
  localparam int B_ZERO_A   = 4;
  localparam int B_CARRY    = 5;
  localparam int B_ADD      = 6;
  localparam int B_Z_LD     = 7;
  localparam int B_Z_DRV    = 8;
  localparam int B_WAIT     = 9;
  localparam int B_MDR_DRV  = 10;
  localparam int B_IR_LD    = 11;
  localparam int B_ADDR_DRV = 12;
  localparam int B_Y_LD     = 13;
  localparam int B_SET_CC   = 14;
  localparam int B_END      = 15;
  localparam int B_SRC_DRV  = 16;
  localparam int B_DST_LD   = 17;
  localparam int B_R1_DRV   = 18;
  localparam int B_R1_LD    = 19;

  typedef logic [CW_W-1:0] cw_t;

  localparam logic [OP_W-1:0] OPC_MOVE = 4'd1;
  localparam logic [OP_W-1:0] OPC_ADD  = 4'd2;
  localparam logic [OP_W-1:0] OPC_BRN  = 4'd3;

  typedef enum logic [1:0] {RT_MOVE, RT_ADD, RT_BRN, RT_BAD} routine_e;

  function automatic cw_t bit_of(input int pos);
    cw_t v;
    v = '0;
    v[pos] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/mseq_decode.sv
module mseq_decode
  import mseq_pkg::*;
#(
  parameter int OPW = OP_W
) (
  input  logic [OPW-1:0] opcode,
  output routine_e       routine
);
  always_comb begin
    unique case (opcode)
      OPC_MOVE: routine = RT_MOVE;
      OPC_ADD:  routine = RT_ADD;
      OPC_BRN:  routine = RT_BRN;
      default:  routine = RT_BAD;
    endcase
  end
endmodule

// File: rtl/mseq_oplatch.sv
module mseq_oplatch
  import mseq_pkg::*;
#(
  parameter int SW = STEP_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] step,
  input  routine_e      live,
  output routine_e      routine
);
  localparam logic [SW-1:0] CAPTURE_STEP = SW'(FETCH_LEN);

  routine_e held_q;
  logic     at_capture;

  assign at_capture = (step == CAPTURE_STEP);

  always_ff @(posedge clk) begin
    if (rst)             held_q <= RT_BAD;
    else if (at_capture) held_q <= live;
  end

  assign routine = at_capture ? live : held_q;

  AST_ROUTINE_HELD: assert property (@(posedge clk) disable iff (rst)
    (step > CAPTURE_STEP + 1'b1) |-> $stable(held_q)); // R11
endmodule

// File: rtl/mseq_store.sv
module mseq_store
  import mseq_pkg::*;
#(
  parameter int SW = STEP_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] step,
  input  routine_e      routine,
  input  logic          flag_n,
  output cw_t           word,
  output logic          illegal
);
  cw_t fetch_w, exec_w;

  always_comb begin
    unique case (int'(step))
      0: fetch_w = bit_of(B_PC_DRV) | bit_of(B_MAR_LD) | bit_of(B_MEM_RD) |
                   bit_of(B_ZERO_A) | bit_of(B_CARRY) | bit_of(B_ADD) | bit_of(B_Z_LD);
      1: fetch_w = bit_of(B_Z_DRV) | bit_of(B_PC_LD) | bit_of(B_WAIT);
      2: fetch_w = bit_of(B_MDR_DRV) | bit_of(B_IR_LD);
      default: fetch_w = '0;
    endcase
  end

  always_comb begin
    exec_w  = bit_of(B_END);
    illegal = 1'b0;
    unique case (routine)
      RT_MOVE: exec_w = bit_of(B_SRC_DRV) | bit_of(B_DST_LD) | bit_of(B_END);
      RT_ADD: begin
        unique case (int'(step))
          3: exec_w = bit_of(B_ADDR_DRV) | bit_of(B_MAR_LD) | bit_of(B_MEM_RD);
          4: exec_w = bit_of(B_R1_DRV) | bit_of(B_Y_LD) | bit_of(B_WAIT);
          5: exec_w = bit_of(B_MDR_DRV) | bit_of(B_ADD) | bit_of(B_Z_LD) | bit_of(B_SET_CC);
          default: exec_w = bit_of(B_Z_DRV) | bit_of(B_R1_LD) | bit_of(B_END);
        endcase
      end
      RT_BRN: begin
        unique case (int'(step))
          3: exec_w = bit_of(B_PC_DRV) | bit_of(B_Y_LD) | (flag_n ? '0 : bit_of(B_END));
          4: exec_w = bit_of(B_ADDR_DRV) | bit_of(B_ADD) | bit_of(B_Z_LD);
          default: exec_w = bit_of(B_Z_DRV) | bit_of(B_PC_LD) | bit_of(B_END);
        endcase
      end
      default: illegal = (int'(step) >= FETCH_LEN);
    endcase
  end

  assign word = (int'(step) < FETCH_LEN) ? fetch_w : exec_w;

  AST_FETCH_NO_CC: assert property (@(posedge clk) disable iff (rst)
    (int'(step) < FETCH_LEN) |-> !word[B_SET_CC]); // R9
  AST_CC_ONLY_ADD: assert property (@(posedge clk) disable iff (rst)
    word[B_SET_CC] |-> (routine == RT_ADD && int'(step) == 5)); // R9
  AST_BAD_ENDS: assert property (@(posedge clk) disable iff (rst)
    illegal |-> word[B_END]); // R10
endmodule

// File: rtl/mseq_counter.sv
module mseq_counter #(
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wait_req,
  input  logic          mem_done,
  input  logic          finish,
  output logic [SW-1:0] step
);
  logic stall;
  assign stall = wait_req && !mem_done;

  always_ff @(posedge clk) begin
    if (rst)         step <= '0;
    else if (!stall) step <= finish ? '0 : step + 1'b1;
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wait_req && !mem_done) |=> $stable(step)); // R4
  AST_END_RESTART: assert property (@(posedge clk) disable iff (rst)
    (finish && !(wait_req && !mem_done)) |=> (step == '0)); // R5
  AST_STEP_INC: assert property (@(posedge clk) disable iff (rst)
    (!finish && !(wait_req && !mem_done)) |=> (step == $past(step) + 1'b1)); // R5
endmodule

// File: rtl/mseq_sequencer.sv
module mseq_sequencer
  import mseq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] ir_opcode,
  input  logic            flag_n,
  input  logic            mem_done,
  output logic [CW_W-1:0] ctrl,
  output logic [STEP_W-1:0] step_idx,
  output logic            illegal_op
);
  routine_e live_rt, cur_rt;
  cw_t      raw_w;
  logic     raw_ill;

  mseq_decode #(.OPW(OP_W)) u_dec (.opcode(ir_opcode), .routine(live_rt));

  mseq_oplatch #(.SW(STEP_W)) u_lat (
    .clk(clk), .rst(rst), .step(step_idx), .live(live_rt), .routine(cur_rt));

  mseq_store #(.SW(STEP_W)) u_store (
    .clk(clk), .rst(rst), .step(step_idx), .routine(cur_rt), .flag_n(flag_n),
    .word(raw_w), .illegal(raw_ill));

  mseq_counter #(.SW(STEP_W)) u_cnt (
    .clk(clk), .rst(rst), .wait_req(raw_w[B_WAIT]), .mem_done(mem_done),
    .finish(raw_w[B_END]), .step(step_idx));

  assign ctrl       = rst ? '0 : raw_w;
  assign illegal_op = rst ? 1'b0 : raw_ill;

  AST_RESET_STEP: assert property (@(posedge clk) rst |=> (step_idx == '0)); // R1
endmodule

// File: tb/mseq_sequencer_test.sv
module mseq_sequencer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  ir_opcode = 4'd0;
  logic        flag_n = 1'b0;
  logic        mem_done = 1'b0;
  logic [19:0] ctrl;
  logic [2:0]  step_idx;
  logic        illegal_op;

  int checks = 0;
  int errors = 0;
  int age = 99;

  localparam logic [19:0] PCO = 20'h1 << 0,  PCI = 20'h1 << 1,  MARI = 20'h1 << 2,
                          RD  = 20'h1 << 3,  ZA  = 20'h1 << 4,  CIN  = 20'h1 << 5,
                          ADD = 20'h1 << 6,  ZI  = 20'h1 << 7,  ZO   = 20'h1 << 8,
                          WT  = 20'h1 << 9,  MDO = 20'h1 << 10, IRI  = 20'h1 << 11,
                          ADO = 20'h1 << 12, YI  = 20'h1 << 13, CC   = 20'h1 << 14,
                          EN  = 20'h1 << 15, SRC = 20'h1 << 16, DST  = 20'h1 << 17,
                          R1O = 20'h1 << 18, R1I = 20'h1 << 19;

  mseq_sequencer uut (.clk(clk), .rst(rst), .ir_opcode(ir_opcode), .flag_n(flag_n),
    .mem_done(mem_done), .ctrl(ctrl), .step_idx(step_idx), .illegal_op(illegal_op));

  always #2 clk = ~clk;

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [19:0] exp_word(input int s, input int op, input bit n);
    if (s == 0) return PCO | MARI | RD | ZA | CIN | ADD | ZI;   // R2
    if (s == 1) return ZO | PCI | WT;                           // R3
    if (s == 2) return MDO | IRI;                               // R3
    case (op)
      1: return SRC | DST | EN;                                 // R6
      2: case (s)                                               // R7 R9
           3: return ADO | MARI | RD;
           4: return R1O | YI | WT;
           5: return MDO | ADD | ZI | CC;
           default: return ZO | R1I | EN;
         endcase
      3: case (s)                                               // R8
           3: return PCO | YI | (n ? 20'h0 : EN);
           4: return ADO | ADD | ZI;
           default: return ZO | PCI | EN;
         endcase
      default: return EN;                                       // R10
    endcase
  endfunction

  task automatic run_instr(input int op, input bit n, input int lat, input bit scramble);
    int es = 0;
    int cyc = 0;
    int want;
    bit done = 0;
    logic [19:0] ew;
    ir_opcode = 4'(op);
    flag_n = n;
    while (!done && cyc < 100) begin
      mem_done = (age >= lat);
      if (scramble && es >= 4) ir_opcode = 4'(op) ^ 4'(cyc + 5);   // R11
      #1;
      ew = exp_word(es, op, n);
      check(32'(step_idx), 32'(es), "R4 R5 step");
      check(32'(ctrl), 32'(ew), (es >= 4 && scramble) ? "R11 ctrl" : "R2 R3 R6 R7 R8 R9 ctrl");
      check(32'(illegal_op), 32'((es == 3) && !(op inside {1, 2, 3})), "R10 illegal");
      if (!(ew[9] && !mem_done)) begin
        if (ew[15]) done = 1;
        else es++;
      end
      @(posedge clk);
      age = ew[3] ? 0 : age + 1;
      cyc++;
      @(negedge clk);
    end
    case (op)
      1: want = 4 + lat;
      2: want = 7 + 2 * lat;
      3: want = (n ? 6 : 4) + lat;
      default: want = 4 + lat;
    endcase
    check(32'(cyc), 32'(want), "R4 instruction length");
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(32'(ctrl), 32'h0, "R1 ctrl zero in reset");
    check(32'(step_idx), 32'h0, "R1 step zero in reset");
    rst = 1'b0;
    for (int op = 0; op < 16; op++)
      for (int n = 0; n < 2; n++)
        for (int lat = 0; lat < 4; lat++)
          run_instr(op, n[0], lat, lat == 2);
    // R1: reset in the middle of a stalled add
    ir_opcode = 4'd2;
    mem_done = 1'b0;
    age = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b1;
    #1;
    check(32'(ctrl), 32'h0, "R1 ctrl zero mid-instruction");
    @(negedge clk);
    check(32'(step_idx), 32'h0, "R1 step after reset");
    rst = 1'b0;
    age = 99;
    run_instr(1, 1'b0, 0, 1'b0);
    run_instr(3, 1'b1, 1, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule